// File: doc/BRIEF.md
# Parallel Flash Programming Port

This block is the device side of a byte-wide parallel programming mode for a 2 KB code store. An external programmer raises an enable line, optionally asserts a high-voltage flag, selects an operation on four mode lines and exchanges bytes over an 8-bit data bus. Addresses are never presented on pins. An internal counter clears when the enable line rises and steps once on each rising edge of an advance input. The programmer walks the array by pulsing that input between operations.

Byte writes and chip erase are self-timed. A ready output stays low while either runs. During a byte write, a verify read of the byte being written returns the complement of its new bit 7. This lets the programmer poll for completion without watching the ready line. Two lock bits restrict access. The first blocks further code programming. With both set, verify reads are also blocked. Only a chip erase clears them, and there is no read path for them. A signature read returns fixed identification bytes. Strobes that arrive at the wrong time are dropped and latch a sticky error flag. Write and erase durations are counts of clock cycles set by parameters. All inputs are treated as synchronous to `clk`.

Top module: `fpgm_port`

## Requirements
- R1: After `rst_n` is released with all inputs idle, `rdy_o` is 1, `err_o` is 0 and `data_oe_o` is 0.
- R2: The address counter clears to 0 in the cycle after `prog_en_i` rises. Otherwise it adds 1 after each rising edge of `adv_i`, and it wraps from 0x7FF to 0x000. When both inputs rise in the same cycle, the clear wins.
- R3: Mode 4'b0111 is a code write. With `prog_en_i` and `hv_en_i` high, a rising edge of `strobe_n_i` stores the bitwise AND of the stored byte and `data_i` at the current address. Bits can therefore only go from 1 to 0.
- R4: `rdy_o` is 0 from the cycle after an accepted write strobe rises, for WRITE_CYC cycles, and then returns to 1.
- R5: While a code write is in progress, a verify read at the target address returns bit 7 as the complement of the new data's bit 7. Bits 6:0 return the byte as stored before the write. Once the write is done, the read returns the true stored byte.
- R6: Mode 4'b1000 is chip erase. If `strobe_n_i` is held low for at least ERASE_HOLD cycles and then released, every byte is set to 0xFF and both lock bits are cleared. `rdy_o` is 0 while the erase runs.
- R7: An erase strobe released before ERASE_HOLD low cycles has no effect on the array or on `rdy_o`, and it sets `err_o`.
- R8: Mode 4'b1111 sets the first lock bit. While that bit is set, a code-write strobe leaves the array unchanged and sets `err_o`.
- R9: Mode 4'b1110 sets the second lock bit. With both lock bits set, a verify read keeps `data_oe_o` at 0. No mode reads out the lock bits.
- R10: Mode 4'b0000 with `prog_en_i` high and `hv_en_i` low is a signature read. It returns 0x1E at address 0, 0x21 at address 1 and 0xFF at any other address, whatever the lock bits hold.
- R11: A write, lock or erase strobe that rises while `rdy_o` is 0 is ignored and sets `err_o`. `err_o` stays at 1 until `rst_n` is asserted.
- R12: Mode 4'b1100 with `prog_en_i` high and `hv_en_i` low is a verify read. It drives `data_oe_o` high and returns the stored byte at the current address on `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| prog_en_i | input | 1 | Programming-mode enable; its rising edge clears the address |
| hv_en_i | input | 1 | High-voltage flag; enables write, lock and erase operations |
| adv_i | input | 1 | Address advance; each rising edge adds one |
| strobe_n_i | input | 1 | Active-low program strobe |
| mode_i | input | 4 | Operation select |
| data_i | input | DATA_W | Write data from the bus pad |
| data_o | output | DATA_W | Read data to the bus pad |
| data_oe_o | output | 1 | Read-data output enable for the bus pad |
| rdy_o | output | 1 | 1 when ready, 0 while busy |
| err_o | output | 1 | Sticky flag for rejected strobes |

## Verification
Two functions can land on the same clock edge. The address clear triggered by the rising edge of `prog_en_i` can coincide with an increment from `adv_i`. The bench lowers the enable line, steps the counter away from zero, and then raises `prog_en_i` and `adv_i` on the same negative edge. It judges the outcome through signature reads. The first read must return the address-0 byte 0x1E, and two further steps must give 0x21 and then 0xFF. A second overlap is a strobe arriving while a write is still running. The bench checks that this strobe raises `err_o` and that the array keeps only the first byte.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

  typedef enum logic [3:0] {
    MD_SIG      = 4'b0000,
    MD_PGM_CODE = 4'b0111,
    MD_ERASE    = 4'b1000,
    MD_VERIFY   = 4'b1100,
    MD_PGM_LK2  = 4'b1110,
    MD_PGM_LK1  = 4'b1111
  } fpgm_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_ERASE = 2'd2
  } fpgm_state_e;

  typedef enum logic [1:0] {
    WK_CODE = 2'd0,
    WK_LK1  = 2'd1,
    WK_LK2  = 2'd2
  } fpgm_kind_e;

  // A write can only clear bits: the new cell value is old AND new.
  function automatic logic [7:0] merge_byte(input logic [7:0] stored,
                                            input logic [7:0] incoming);
    return stored & incoming;
  endfunction

  // Value seen on a read of the byte being written while the write runs.
  function automatic logic [7:0] poll_byte(input logic [7:0] stored,
                                           input logic [7:0] pending);
    return {~pending[7], stored[6:0]};
  endfunction

  function automatic logic [7:0] sig_byte(input logic [31:0] a,
                                          input logic [7:0]  b0,
                                          input logic [7:0]  b1);
    if (a == 32'd0) return b0;
    if (a == 32'd1) return b1;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/fpgm_edge.sv
module fpgm_edge #(
  parameter int            N       = 1,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/fpgm_addr.sv
module fpgm_addr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   addr <= '0;
    else if (clr) addr <= '0;
    else if (inc) addr <= addr + 1'b1;
endmodule

// File: rtl/fpgm_array.sv
module fpgm_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int NW = 1 << AW;
  logic [DW-1:0] mem [NW];

  always_ff @(posedge clk)
    if (we) mem[waddr] <= wdata;

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
  import fpgm_pkg::*;
#(
  parameter int AW         = 11,
  parameter int DW         = 8,
  parameter int WRITE_CYC  = 240,
  parameter int ERASE_HOLD = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_ok,
  input  logic          strobe_low,
  input  logic          strobe_rise,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] tgt_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] tgt_addr,
  output logic [DW-1:0] tgt_data,
  output logic          busy_code,
  output logic          ready,
  output logic          lk1,
  output logic          lk2,
  output logic          err,
  output logic          ev_wr_start,
  output logic          ev_wr_commit,
  output logic          ev_er_start,
  output logic          ev_er_done,
  output logic          ev_reject
);
  localparam int TW = $clog2(WRITE_CYC + 1);
  localparam int HW = $clog2(ERASE_HOLD + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(WRITE_CYC - 1);
  localparam logic [HW-1:0] H_MAX  = HW'(ERASE_HOLD);

  fpgm_state_e   state_q;
  fpgm_kind_e    kind_q;
  logic [TW-1:0] timer_q;
  logic [HW-1:0] hold_q;
  logic [AW-1:0] sweep_q;

  logic is_pgm, is_lk, is_er, req, idle;

  // Count how long the strobe has been low (saturating).
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          hold_q <= '0;
    else if (!strobe_low)                hold_q <= '0;
    else if (hold_q != H_MAX)            hold_q <= hold_q + 1'b1;

  always_comb begin
    is_pgm = (mode == MD_PGM_CODE);
    is_lk  = (mode == MD_PGM_LK1) || (mode == MD_PGM_LK2);
    is_er  = (mode == MD_ERASE);
    req    = prog_ok && strobe_rise && (is_pgm || is_lk || is_er);
    idle   = (state_q == ST_IDLE);
  end

  assign ev_wr_start  = req && idle && ((is_pgm && !lk1) || is_lk);
  assign ev_er_start  = req && idle && is_er && (hold_q >= H_MAX);
  assign ev_reject    = req && !ev_wr_start && !ev_er_start;
  assign ev_wr_commit = (state_q == ST_WRITE) && (timer_q == '0);
  assign ev_er_done   = (state_q == ST_ERASE) && (sweep_q == '1);

  assign mem_we    = (ev_wr_commit && kind_q == WK_CODE) || (state_q == ST_ERASE);
  assign mem_waddr = (state_q == ST_ERASE) ? sweep_q : tgt_addr;
  assign mem_wdata = (state_q == ST_ERASE) ? '1 : merge_byte(tgt_rd, tgt_data);

  assign busy_code = (state_q == ST_WRITE) && (kind_q == WK_CODE);
  assign ready     = idle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= WK_CODE;
      timer_q  <= '0;
      sweep_q  <= '0;
      tgt_addr <= '0;
      tgt_data <= '0;
      lk1      <= 1'b0;
      lk2      <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (ev_reject) err <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (ev_wr_start) begin
            state_q  <= ST_WRITE;
            timer_q  <= T_LOAD;
            tgt_addr <= addr;
            tgt_data <= wdata_in;
            kind_q   <= is_pgm ? WK_CODE :
                        (mode == MD_PGM_LK1) ? WK_LK1 : WK_LK2;
          end else if (ev_er_start) begin
            state_q <= ST_ERASE;
            sweep_q <= '0;
          end
        end
        ST_WRITE: begin
          if (ev_wr_commit) begin
            state_q <= ST_IDLE;
            if (kind_q == WK_LK1) lk1 <= 1'b1;
            if (kind_q == WK_LK2) lk2 <= 1'b1;
          end else begin
            timer_q <= timer_q - 1'b1;
          end
        end
        ST_ERASE: begin
          sweep_q <= sweep_q + 1'b1;
          if (ev_er_done) begin
            state_q <= ST_IDLE;
            lk1     <= 1'b0;
            lk2     <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
endmodule

// File: rtl/fpgm_port.sv
module fpgm_port
  import fpgm_pkg::*;
#(
  parameter int         ADDR_W     = 11,
  parameter int         DATA_W     = 8,
  parameter int         WRITE_CYC  = 240,
  parameter int         ERASE_HOLD = 2000,
  parameter logic [7:0] SIG_B0     = 8'h1E,
  parameter logic [7:0] SIG_B1     = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en_i,
  input  logic              hv_en_i,
  input  logic              adv_i,
  input  logic              strobe_n_i,
  input  logic [3:0]        mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rdy_o,
  output logic              err_o
);
  // Edge vector bit order: 0 enable, 1 advance, 2 strobe
  logic [2:0] rise;
  fpgm_edge #(.N(3), .RST_VAL(3'b100)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({strobe_n_i, adv_i, prog_en_i}),
    .rise(rise)
  );

  logic [ADDR_W-1:0] addr_q;
  fpgm_addr #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(rise[0]), .inc(rise[1]), .addr(addr_q)
  );

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, tgt_addr;
  logic [DATA_W-1:0] mem_wdata, tgt_data, rd_cur, rd_tgt;
  logic              busy_code, lk1, lk2;
  logic              ev_wr_start, ev_wr_commit, ev_er_start, ev_er_done, ev_reject;

  fpgm_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(addr_q), .rdata_a(rd_cur),
    .raddr_b(tgt_addr), .rdata_b(rd_tgt)
  );

  fpgm_seq #(.AW(ADDR_W), .DW(DATA_W), .WRITE_CYC(WRITE_CYC),
             .ERASE_HOLD(ERASE_HOLD)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .prog_ok(prog_en_i && hv_en_i),
    .strobe_low(!strobe_n_i), .strobe_rise(rise[2]),
    .mode(mode_i), .addr(addr_q), .wdata_in(data_i), .tgt_rd(rd_tgt),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .busy_code(busy_code),
    .ready(rdy_o), .lk1(lk1), .lk2(lk2), .err(err_o),
    .ev_wr_start(ev_wr_start), .ev_wr_commit(ev_wr_commit),
    .ev_er_start(ev_er_start), .ev_er_done(ev_er_done), .ev_reject(ev_reject)
  );

  logic rd_window, sig_sel, ver_sel;
  always_comb begin
    rd_window = prog_en_i && !hv_en_i;
    sig_sel   = rd_window && (mode_i == MD_SIG);
    ver_sel   = rd_window && (mode_i == MD_VERIFY);
    data_oe_o = sig_sel || (ver_sel && !(lk1 && lk2));
    if (!data_oe_o)
      data_o = '0;
    else if (sig_sel)
      data_o = DATA_W'(sig_byte(32'(addr_q), SIG_B0, SIG_B1));
    else if (busy_code && (addr_q == tgt_addr))
      data_o = poll_byte(rd_cur, tgt_data);
    else
      data_o = rd_cur;
  end
endmodule

// File: rtl/fpgm_port_chk.sv
module fpgm_port_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prog_en_i,
  input logic          hv_en_i,
  input logic          adv_i,
  input logic [3:0]    mode_i,
  input logic          data_oe_o,
  input logic          rdy_o,
  input logic          err_o,
  input logic [AW-1:0] addr_q,
  input logic          lk1,
  input logic          lk2,
  input logic          mem_we,
  input logic          ev_wr_start,
  input logic          ev_wr_commit,
  input logic          ev_er_done,
  input logic          ev_reject
);
  p_addr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_en_i) |=> (addr_q == '0));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(prog_en_i) && $rose(adv_i)) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

  p_write_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !rdy_o);

  p_ready_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_start |=> !rdy_o);

  p_ready_returns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_commit |=> rdy_o);

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lk1) || $fell(lk2)) |-> $past(ev_er_done));

  p_verify_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk1 && lk2 && prog_en_i && !hv_en_i && mode_i == 4'b1100) |-> !data_oe_o);

  p_reject_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> err_o);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind fpgm_port fpgm_port_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en_i(prog_en_i), .hv_en_i(hv_en_i),
  .adv_i(adv_i), .mode_i(mode_i), .data_oe_o(data_oe_o), .rdy_o(rdy_o),
  .err_o(err_o), .addr_q(addr_q), .lk1(lk1), .lk2(lk2), .mem_we(mem_we),
  .ev_wr_start(ev_wr_start), .ev_wr_commit(ev_wr_commit),
  .ev_er_done(ev_er_done), .ev_reject(ev_reject)
);

// File: tb/fpgm_port_tb.sv
module fpgm_port_tb_top;
  localparam int WR = 20;
  localparam int EH = 40;
  localparam int NW = 2048;
  localparam logic [3:0] M_SIG = 4'b0000, M_PGM = 4'b0111, M_ERA = 4'b1000,
                         M_VER = 4'b1100, M_LK2 = 4'b1110, M_LK1 = 4'b1111;

  // {advance first, byte written, expected read-back}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'hA5, 8'hA5}, {1'b0, 8'h0F, 8'h05}, {1'b1, 8'h3C, 8'h3C},
    {1'b1, 8'hFF, 8'hFF}, {1'b0, 8'h81, 8'h81}, {1'b1, 8'h00, 8'h00},
    {1'b1, 8'h7E, 8'h7E}, {1'b0, 8'hFF, 8'h7E}
  };

  logic clk = 0, rst_n = 0, pen = 0, hv = 0, adv = 0, strb = 1;
  logic [3:0] mode = M_VER;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic oe, rdy, err;
  int nvec = 0, nfail = 0;
  logic [7:0] v;
  logic vo;

  always #2.5 clk = ~clk;

  fpgm_port #(.WRITE_CYC(WR), .ERASE_HOLD(EH)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_en_i(pen), .hv_en_i(hv), .adv_i(adv),
    .strobe_n_i(strb), .mode_i(mode), .data_i(din), .data_o(dout),
    .data_oe_o(oe), .rdy_o(rdy), .err_o(err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic adv_pulse(); adv = 1; tick(1); adv = 0; tick(1); endtask
  task automatic strobe(input int low); strb = 0; tick(low); strb = 1; tick(1); endtask
  task automatic pgm(input logic [3:0] m, input logic [7:0] d);
    mode = m; din = d; hv = 1; tick(1); strobe(2); tick(WR + 2); hv = 0;
  endtask
  task automatic rd(input logic [3:0] m, output logic [7:0] val, output logic e);
    mode = m; hv = 0; tick(1); val = dout; e = oe;
  endtask
  task automatic erase_full();
    mode = M_ERA; hv = 1; tick(1); strobe(EH + 2);
    check("R6 ready low during erase", {7'd0, rdy}, 8'd0);
    tick(NW + 4); hv = 0;
  endtask
  task automatic reenable(); pen = 0; tick(1); pen = 1; tick(1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(2);
    check("R1 rdy", {7'd0, rdy}, 8'd1);
    check("R1 err", {7'd0, err}, 8'd0);
    check("R1 oe",  {7'd0, oe}, 8'd0);

    pen = 1; tick(1);
    erase_full();
    rd(M_VER, v, vo);
    check("R12 oe on verify", {7'd0, vo}, 8'd1);
    check("R6 erased byte", v, 8'hFF);
    reenable();

    // Table walk: merge rule, address stepping, read-back
    foreach (VEC[i]) begin
      if (VEC[i][16]) adv_pulse();
      pgm(M_PGM, VEC[i][15:8]);
      rd(M_VER, v, vo);
      check("R3/R12 table read-back", v, VEC[i][7:0]);
    end

    // Data polling on address 5 (erased)
    adv_pulse();
    mode = M_PGM; din = 8'h80; hv = 1; tick(1); strobe(2);
    check("R4 busy after strobe", {7'd0, rdy}, 8'd0);
    hv = 0; mode = M_VER; tick(3);
    check("R5 polling value", dout, 8'h7F);
    tick(WR + 2);
    check("R4 ready after write", {7'd0, rdy}, 8'd1);
    rd(M_VER, v, vo);
    check("R5 true data after write", v, 8'h80);

    // Collision: enable rise with advance rise in the same cycle
    pen = 0; tick(1); adv_pulse(); adv_pulse();
    pen = 1; adv = 1; tick(1); adv = 0; tick(1);
    rd(M_SIG, v, vo);
    check("R2 clear wins / R10 sig0", v, 8'h1E);
    adv_pulse(); rd(M_SIG, v, vo);
    check("R10 sig1", v, 8'h21);
    adv_pulse(); rd(M_SIG, v, vo);
    check("R10 sig other", v, 8'hFF);

    // Wrap: go to 0x7FF, write, then step once back to 0
    reenable();
    for (int k = 0; k < NW - 1; k++) adv_pulse();
    pgm(M_PGM, 8'h3C);
    rd(M_VER, v, vo);
    check("R12 top address", v, 8'h3C);
    adv_pulse(); rd(M_VER, v, vo);
    check("R2 wrap to 0", v, 8'h05);

    // Locks at address 5 (holds 0x80)
    reenable();
    for (int k = 0; k < 5; k++) adv_pulse();
    pgm(M_LK1, 8'h00);
    check("R8 lock write no error", {7'd0, err}, 8'd0);
    pgm(M_PGM, 8'h00);
    check("R8 locked write err", {7'd0, err}, 8'd1);
    rd(M_VER, v, vo);
    check("R8 locked byte unchanged", v, 8'h80);
    check("R9 verify allowed with lock1 only", {7'd0, vo}, 8'd1);
    pgm(M_LK2, 8'h00);
    rd(M_VER, v, vo);
    check("R9 verify blocked", {7'd0, vo}, 8'd0);
    rd(M_SIG, v, vo);
    check("R10 sig under lock", v, 8'hFF);
    check("R10 sig oe under lock", {7'd0, vo}, 8'd1);
    erase_full();
    rd(M_VER, v, vo);
    check("R6 locks cleared", {7'd0, vo}, 8'd1);
    check("R6 byte erased", v, 8'hFF);
    check("R11 err sticky", {7'd0, err}, 8'd1);

    // Short erase
    rst_n = 0; tick(2); rst_n = 1; tick(1);
    check("R11 err cleared by reset", {7'd0, err}, 8'd0);
    pgm(M_PGM, 8'h5A);
    mode = M_ERA; hv = 1; tick(1); strobe(5);
    check("R7 no erase started", {7'd0, rdy}, 8'd1);
    hv = 0; tick(1);
    check("R7 short erase err", {7'd0, err}, 8'd1);
    rd(M_VER, v, vo);
    check("R7 data kept", v, 8'h5A);

    // Strobe while busy
    rst_n = 0; tick(2); rst_n = 1; tick(1);
    adv_pulse();
    mode = M_PGM; din = 8'hC3; hv = 1; tick(1); strobe(2);
    din = 8'h00; strobe(2);
    check("R11 busy strobe err", {7'd0, err}, 8'd1);
    tick(WR + 2); hv = 0;
    rd(M_VER, v, vo);
    check("R11 second write ignored", v, 8'hC3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule